// File: doc/BRIEF.md
# Column Command Spacing Tracker

This block sits beside the command scheduler of a DRAM channel and keeps, for every bank of every rank, the earliest cycle at which a READ or WRITE burst may be sent to that bank. Each time the scheduler reports a burst through the issue strobe, every bank's window moves forward. The distance depends on where the bank sits relative to the burst's target. A bank in the target's own bank group gets the long CAS-to-CAS gap. Another group in the same rank gets the short gap, which is one burst length. Any bank in another rank gets the short gap plus a rank-switch allowance. A window never moves backwards.

The block also keeps a data-bus busy-until time. A burst that reverses direction within the same rank as the previous burst first adds a turnaround bubble. Write-to-read and read-to-write use different bubbles. A change of rank adds no bubble, because that cost is already in the other-rank column window. The burst then starts at the later of its issue cycle and the padded busy time, and holds the bus for one burst length. The scheduler supplies the current cycle on `now_i`. It reads one "column allowed" flag per bank and the busy-until time.

Top module: `col_spacing_tracker`

## Requirements
- R1: After reset every bank window and the bus busy-until time are 0, the active rank is 0 and the last direction is read (iss_dir_i = 0 read, 1 write). A first write to rank 0 therefore pays the read-to-write bubble.
- R2: An issued burst at cycle t to rank r, bank k raises the window of every bank in rank r with the same group as k to at least t + T_CCD_L. With grouping enabled, a bank's group is its bank number modulo GROUPS.
- R3: The same burst raises the window of every other-group bank of rank r to at least t + T_BURST.
- R4: The same burst raises the window of every bank of every other rank to at least t + T_BURST + T_CS.
- R5: Every update keeps the larger of the stored window and the new bound. Without an issue the windows hold.
- R6: Flag col_ok_o[r*BANKS + b] is 1 exactly when now_i is at or past that bank's window.
- R7: A read issued to the active rank after a write adds T_WTR + T_CL to the busy time before the new burst is placed.
- R8: A write issued to the active rank after a read adds T_RTW to the busy time before the new burst is placed.
- R9: A burst to a rank other than the active rank adds no bubble, whatever its direction.
- R10: The new busy-until time is max(t, busy + bubble) + T_BURST, so successive bursts hold the bus at least T_BURST apart.
- R11: Every issued burst makes its rank the active rank and its direction the last direction.
- R12: With GROUP_EN = 0 only the issued bank itself takes the T_CCD_L bound. The other banks of its rank take T_BURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| iss_vld_i | input | 1 | A burst is issued this cycle |
| iss_rank_i | input | RANK_W | Rank of the issued burst |
| iss_bank_i | input | BANK_W | Bank of the issued burst |
| iss_dir_i | input | 1 | Direction of the issued burst, 0 read, 1 write |
| iss_time_i | input | TIME_W | Command cycle of the issued burst |
| now_i | input | TIME_W | Current cycle, compared against the windows |
| col_ok_o | output | RANKS*BANKS | Per-bank column-allowed flags, index rank*BANKS + bank |
| bus_busy_o | output | TIME_W | Cycle up to which the data bus is occupied |

## Verification
The bench starts with a short directed sequence. It steps through a first write after reset, a read-to-write and a write-to-read turn inside one rank, a rank hop in each direction, and a return to an earlier rank. Each step shows whether the bubble came from the direction change, the rank change or neither. A long pseudo-random run of issues follows over two ranks of four banks. Some issue cycles repeat or step backwards, so stored windows must beat smaller new bounds. After every issue each bank's flag is probed one cycle before and exactly at its predicted window. This separates the same-group, other-group and other-rank gaps. A second instance with grouping disabled, driven by the same stimulus, shows that only the issued bank takes the long gap.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        SP_SAME_GRP   = 2'd0,
        SP_OTHER_GRP  = 2'd1,
        SP_OTHER_RANK = 2'd2
    } spacing_e;

endpackage

// File: rtl/ccs_spacing_sel.sv
module ccs_spacing_sel
    import ccs_pkg::*;
#(
    parameter int RANK_W   = 1,
    parameter int BANK_W   = 2,
    parameter int GROUPS   = 2,
    parameter bit GROUP_EN = 1'b1,
    parameter int MY_RANK  = 0,
    parameter int MY_BANK  = 0
) (
    input  logic [RANK_W-1:0] iss_rank_i,
    input  logic [BANK_W-1:0] iss_bank_i,
    output spacing_e          spc_o
);

    localparam int unsigned MY_GRP = MY_BANK % GROUPS;

    logic same_rank;
    logic same_grp;

    assign same_rank = (iss_rank_i == RANK_W'(MY_RANK));

    generate
        if (GROUP_EN) begin : g_grouped
            always_comb begin
                int unsigned ib;
                ib       = 32'(iss_bank_i);
                same_grp = ((ib % GROUPS) == MY_GRP);
            end
        end else begin : g_flat
            assign same_grp = (iss_bank_i == BANK_W'(MY_BANK));
        end
    endgenerate

    always_comb begin
        if (!same_rank) begin
            spc_o = SP_OTHER_RANK;
        end else if (same_grp) begin
            spc_o = SP_SAME_GRP;
        end else begin
            spc_o = SP_OTHER_GRP;
        end
    end

endmodule

// File: rtl/ccs_bank_window.sv
module ccs_bank_window
    import ccs_pkg::*;
#(
    parameter int TIME_W   = 16,
    parameter int RANK_W   = 1,
    parameter int BANK_W   = 2,
    parameter int GROUPS   = 2,
    parameter bit GROUP_EN = 1'b1,
    parameter int MY_RANK  = 0,
    parameter int MY_BANK  = 0,
    parameter int T_BURST  = 4,
    parameter int T_CCD_L  = 6,
    parameter int T_CS     = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              iss_vld_i,
    input  logic [RANK_W-1:0] iss_rank_i,
    input  logic [BANK_W-1:0] iss_bank_i,
    input  logic [TIME_W-1:0] iss_time_i,
    input  logic [TIME_W-1:0] now_i,
    output logic              col_ok_o
);

    localparam logic [TIME_W-1:0] BURST_T = TIME_W'(T_BURST);
    localparam logic [TIME_W-1:0] CCDL_T  = TIME_W'(T_CCD_L);
    localparam logic [TIME_W-1:0] XRANK_T = TIME_W'(T_BURST + T_CS);

    typedef struct packed {
        logic [TIME_W-1:0] win;
    } win_st_t;

    win_st_t     st_d, st_q;
    spacing_e    spc;
    logic [TIME_W-1:0] gap;
    logic [TIME_W-1:0] bound;

    ccs_spacing_sel #(
        .RANK_W  (RANK_W),
        .BANK_W  (BANK_W),
        .GROUPS  (GROUPS),
        .GROUP_EN(GROUP_EN),
        .MY_RANK (MY_RANK),
        .MY_BANK (MY_BANK)
    ) u_sel (
        .iss_rank_i(iss_rank_i),
        .iss_bank_i(iss_bank_i),
        .spc_o     (spc)
    );

    always_comb begin
        st_d = st_q;
        unique case (spc)
            SP_SAME_GRP:  gap = CCDL_T;
            SP_OTHER_GRP: gap = BURST_T;
            default:      gap = XRANK_T;
        endcase
        bound = iss_time_i + gap;
        if (iss_vld_i && (bound > st_q.win)) begin
            st_d.win = bound;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_ok_o = (now_i >= st_q.win);

    assert_same_group_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_vld_i && spc == SP_SAME_GRP) |=> (st_q.win >= $past(iss_time_i) + CCDL_T))
        else $error("same-group window below long gap");

    assert_other_group_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_vld_i && spc == SP_OTHER_GRP) |=> (st_q.win >= $past(iss_time_i) + BURST_T))
        else $error("other-group window below burst gap");

    assert_other_rank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_vld_i && spc == SP_OTHER_RANK) |=> (st_q.win >= $past(iss_time_i) + XRANK_T))
        else $error("other-rank window below rank gap");

    assert_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_i |=> (st_q.win >= $past(st_q.win)))
        else $error("window moved backwards");

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !iss_vld_i |=> $stable(st_q.win))
        else $error("window changed without issue");

endmodule

// File: rtl/ccs_bus_tracker.sv
module ccs_bus_tracker
    import ccs_pkg::*;
#(
    parameter int TIME_W  = 16,
    parameter int RANK_W  = 1,
    parameter int T_BURST = 4,
    parameter int T_WTR   = 3,
    parameter int T_CL    = 5,
    parameter int T_RTW   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              iss_vld_i,
    input  logic [RANK_W-1:0] iss_rank_i,
    input  dir_e              iss_dir_i,
    input  logic [TIME_W-1:0] iss_time_i,
    output logic [TIME_W-1:0] bus_busy_o
);

    localparam logic [TIME_W-1:0] BURST_T = TIME_W'(T_BURST);
    localparam logic [TIME_W-1:0] W2R_T   = TIME_W'(T_WTR + T_CL);
    localparam logic [TIME_W-1:0] R2W_T   = TIME_W'(T_RTW);

    typedef struct packed {
        logic [TIME_W-1:0] busy;
        logic [RANK_W-1:0] act_rank;
        dir_e              last_dir;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic [TIME_W-1:0] bubble;
    logic [TIME_W-1:0] padded;
    logic [TIME_W-1:0] start;
    logic              same_rank;

    always_comb begin
        st_d      = st_q;
        same_rank = (iss_rank_i == st_q.act_rank);
        bubble    = '0;
        if (same_rank && (iss_dir_i != st_q.last_dir)) begin
            bubble = (st_q.last_dir == DIR_WR) ? W2R_T : R2W_T;
        end
        padded = st_q.busy + bubble;
        start  = (iss_time_i > padded) ? iss_time_i : padded;
        if (iss_vld_i) begin
            st_d.busy     = start + BURST_T;
            st_d.act_rank = iss_rank_i;
            st_d.last_dir = iss_dir_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.busy     <= '0;
            st_q.act_rank <= '0;
            st_q.last_dir <= DIR_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_busy_o = st_q.busy;

    assert_bus_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_i |=> (st_q.busy >= $past(st_q.busy) + BURST_T))
        else $error("burst closer than one burst length");

    assert_bus_after_issue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_i |=> (st_q.busy >= $past(iss_time_i) + BURST_T))
        else $error("burst ends before issue plus burst length");

    assert_rank_hop_no_bubble_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_vld_i && iss_rank_i != st_q.act_rank && iss_time_i <= st_q.busy)
        |=> (st_q.busy == $past(st_q.busy) + BURST_T))
        else $error("rank change added a bubble");

    assert_track_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_i |=> (st_q.act_rank == $past(iss_rank_i) && st_q.last_dir == $past(iss_dir_i)))
        else $error("active rank or direction not recorded");

    assert_bus_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !iss_vld_i |=> $stable(st_q.busy))
        else $error("busy time changed without issue");

endmodule

// File: rtl/col_spacing_tracker.sv
module col_spacing_tracker
    import ccs_pkg::*;
#(
    parameter int RANKS    = 2,
    parameter int BANKS    = 4,
    parameter int GROUPS   = 2,
    parameter bit GROUP_EN = 1'b1,
    parameter int TIME_W   = 16,
    parameter int T_BURST  = 4,
    parameter int T_CCD_L  = 6,
    parameter int T_CS     = 2,
    parameter int T_WTR    = 3,
    parameter int T_CL     = 5,
    parameter int T_RTW    = 2,
    localparam int RANK_W  = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int NFLAGS  = RANKS * BANKS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              iss_vld_i,
    input  logic [RANK_W-1:0] iss_rank_i,
    input  logic [BANK_W-1:0] iss_bank_i,
    input  logic              iss_dir_i,
    input  logic [TIME_W-1:0] iss_time_i,
    input  logic [TIME_W-1:0] now_i,
    output logic [NFLAGS-1:0] col_ok_o,
    output logic [TIME_W-1:0] bus_busy_o
);

    generate
        if (GROUP_EN && (T_CCD_L <= T_BURST)) begin : g_bad_ccd
            $error("long CAS gap must exceed the burst length when grouping is on");
        end
        if (GROUP_EN && ((GROUPS > BANKS) || (BANKS % GROUPS != 0))) begin : g_bad_grp
            $error("banks must divide evenly into groups");
        end
    endgenerate

    generate
        for (genvar r = 0; r < RANKS; r++) begin : g_rank
            for (genvar b = 0; b < BANKS; b++) begin : g_bank
                ccs_bank_window #(
                    .TIME_W  (TIME_W),
                    .RANK_W  (RANK_W),
                    .BANK_W  (BANK_W),
                    .GROUPS  (GROUPS),
                    .GROUP_EN(GROUP_EN),
                    .MY_RANK (r),
                    .MY_BANK (b),
                    .T_BURST (T_BURST),
                    .T_CCD_L (T_CCD_L),
                    .T_CS    (T_CS)
                ) u_win (
                    .clk_i     (clk_i),
                    .rst_ni    (rst_ni),
                    .iss_vld_i (iss_vld_i),
                    .iss_rank_i(iss_rank_i),
                    .iss_bank_i(iss_bank_i),
                    .iss_time_i(iss_time_i),
                    .now_i     (now_i),
                    .col_ok_o  (col_ok_o[r*BANKS + b])
                );
            end
        end
    endgenerate

    ccs_bus_tracker #(
        .TIME_W (TIME_W),
        .RANK_W (RANK_W),
        .T_BURST(T_BURST),
        .T_WTR  (T_WTR),
        .T_CL   (T_CL),
        .T_RTW  (T_RTW)
    ) u_bus (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .iss_vld_i (iss_vld_i),
        .iss_rank_i(iss_rank_i),
        .iss_dir_i (dir_e'(iss_dir_i)),
        .iss_time_i(iss_time_i),
        .bus_busy_o(bus_busy_o)
    );

endmodule

// File: tb/col_spacing_tracker_tb_top.sv
`timescale 1ns/1ps
module col_spacing_tracker_tb_top;

    localparam int NR = 2, NB = 4, NG = 2, TW = 16;
    localparam int TB_BURST = 4, TB_CCDL = 6, TB_CS = 2, TB_WTR = 3, TB_CL = 5, TB_RTW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld = 1'b0;
    logic [0:0]    rank = '0;
    logic [1:0]    bank = '0;
    logic          dir = 1'b0;
    logic [TW-1:0] itime = '0;
    logic [TW-1:0] now = '0;
    logic [NR*NB-1:0] ok_g, ok_f;
    logic [TW-1:0] busy_g, busy_f;

    int checks = 0, fails = 0;
    int ew_g [NR][NB];
    int ew_f [NR][NB];
    int e_busy = 0, e_rank = 0, e_dir = 0;
    int l_rank = 0, l_bank = 0;
    string busy_tag = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    col_spacing_tracker #(.RANKS(NR), .BANKS(NB), .GROUPS(NG), .GROUP_EN(1'b1), .TIME_W(TW),
        .T_BURST(TB_BURST), .T_CCD_L(TB_CCDL), .T_CS(TB_CS), .T_WTR(TB_WTR), .T_CL(TB_CL),
        .T_RTW(TB_RTW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .iss_vld_i(vld), .iss_rank_i(rank), .iss_bank_i(bank),
        .iss_dir_i(dir), .iss_time_i(itime), .now_i(now), .col_ok_o(ok_g), .bus_busy_o(busy_g));

    col_spacing_tracker #(.RANKS(NR), .BANKS(NB), .GROUPS(NG), .GROUP_EN(1'b0), .TIME_W(TW),
        .T_BURST(TB_BURST), .T_CCD_L(TB_CCDL), .T_CS(TB_CS), .T_WTR(TB_WTR), .T_CL(TB_CL),
        .T_RTW(TB_RTW)) dut_flat_i (
        .clk_i(clk), .rst_ni(rst_n), .iss_vld_i(vld), .iss_rank_i(rank), .iss_bank_i(bank),
        .iss_dir_i(dir), .iss_time_i(itime), .now_i(now), .col_ok_o(ok_f), .bus_busy_o(busy_f));

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Probe one flag just below and exactly at its predicted window (R6).
    task automatic probe(input bit flat, input int idx, input int w, input string tag);
        logic f;
        if (w > 0) begin
            now = TW'(w - 1);
            #0.1;
            f = flat ? ok_f[idx] : ok_g[idx];
            chk(f == 1'b0, "R6", int'(f), 0);
        end
        now = TW'(w);
        #0.1;
        f = flat ? ok_f[idx] : ok_g[idx];
        chk(f == 1'b1, tag, int'(f), 1);
    endtask

    task automatic check_all();
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < NB; b++) begin
                string tg;
                if (r != l_rank) tg = "R4";
                else if ((b % NG) == (l_bank % NG)) tg = "R2";
                else tg = "R3";
                probe(1'b0, r*NB + b, ew_g[r][b], tg);
                probe(1'b1, r*NB + b, ew_f[r][b], "R12");
            end
        end
        chk(int'(busy_g) == e_busy, busy_tag, int'(busy_g), e_busy);
        chk(int'(busy_f) == e_busy, "R10", int'(busy_f), e_busy);
    endtask

    task automatic issue(input int rk, input int bk, input int dr, input int t);
        int bub, base, st;
        @(negedge clk);
        vld = 1'b1; rank = 1'(rk); bank = 2'(bk); dir = 1'(dr); itime = TW'(t);
        @(negedge clk);
        vld = 1'b0;
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < NB; b++) begin
                int dg, df;
                if (r != rk) begin
                    dg = TB_BURST + TB_CS; df = dg;
                end else begin
                    dg = ((b % NG) == (bk % NG)) ? TB_CCDL : TB_BURST;
                    df = (b == bk) ? TB_CCDL : TB_BURST;
                end
                if (t + dg > ew_g[r][b]) ew_g[r][b] = t + dg;
                if (t + df > ew_f[r][b]) ew_f[r][b] = t + df;
            end
        end
        bub = 0;
        busy_tag = "R10";
        if (rk != e_rank) busy_tag = "R9";
        else if (dr != e_dir) begin
            bub = (e_dir == 1) ? TB_WTR + TB_CL : TB_RTW;
            busy_tag = (e_dir == 1) ? "R7" : "R8";
        end
        base = e_busy + bub;
        st = (t > base) ? t : base;
        e_busy = st + TB_BURST;
        e_rank = rk; e_dir = dr;    // R11
        l_rank = rk; l_bank = bk;
        check_all();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rng;
        int t;
        for (int r = 0; r < NR; r++) for (int b = 0; b < NB; b++) begin
            ew_g[r][b] = 0; ew_f[r][b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all windows zero, busy zero
        now = '0;
        #0.1;
        chk(ok_g == '1, "R1", int'(ok_g), (1 << (NR*NB)) - 1);
        chk(ok_f == '1, "R1", int'(ok_f), (1 << (NR*NB)) - 1);
        chk(busy_g == '0, "R1", int'(busy_g), 0);
        // R1/R8: first write to rank 0 pays read-to-write bubble: busy 0+2 -> 6
        issue(0, 0, 1, 0);
        chk(int'(busy_g) == 6, "R1", int'(busy_g), 6);
        issue(0, 1, 0, 3);    // R7 write-to-read, same rank
        issue(1, 2, 1, 5);    // R9 rank hop with direction change
        issue(1, 3, 0, 6);    // R7 on rank 1, R11 active rank moved
        issue(0, 2, 0, 7);    // R9 back to rank 0
        issue(0, 3, 1, 60);   // R8 with idle bus, issue time dominates
        issue(0, 1, 1, 55);   // R5 earlier issue time, stored windows kept
        rng = 32'h1234_5678;
        t = 70;
        for (int i = 0; i < 60; i++) begin
            rng = rng * 32'd1664525 + 32'd1013904223;
            t = t + int'(rng[18:16]) - 2;
            if (t < 0) t = 0;
            issue(int'(rng[24]), int'(rng[27:26]), int'(rng[29]), t);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule